// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides the clock cycle in which the analog-to-digital converter's sequencer begins a new conversion. A start can come from software, as a start request bit, or from hardware, as a rising edge on one of several trigger lines. A select field picks which trigger line is watched. One line is normally wired to the converter's own conversion-complete flag, so that conversions can run back to back.

A hardware start does two things. It issues a one-cycle start pulse to the sequencer, and it resets the conversion clock prescaler, so that sampling begins at a fixed phase after the trigger. Only the moment a line goes high counts; a line that stays high does not. An edge that arrives while the sequencer reports busy is dropped and is not stored for later. All control inputs are plain levels and all outputs are single-cycle pulses; there is no handshake at the block's edge.

Top module: `adc_trig_start`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `conv_start` and `psc_reset` are low.
- R2: A `sw_start` sampled high while `busy` is low gives `conv_start` high for one cycle on the next cycle, whatever the value of `auto_en`. A start from software leaves `psc_reset` low.
- R3: With `auto_en` high and `busy` low, a rising edge (0 then 1 in consecutive cycles) on `trig_lines[src_sel]` gives both `conv_start` and `psc_reset` high for exactly one cycle, on the cycle after the line is first seen high.
- R4: With `auto_en` low, edges on the trigger lines have no effect on either output.
- R5: Edges on trigger lines other than the one at index `src_sel` have no effect.
- R6: A rising edge seen while `busy` is high is dropped, and no start follows when `busy` later falls.
- R7: A selected line that is still high when `busy` falls does not start a conversion. The line must go low and then high again to start one.
- R8: In a cycle where `src_sel` differs from its value in the previous cycle, no hardware start is produced, even if the newly selected line is high.
- R9: When the watched line is the conversion-complete flag (index 7 by convention), the flag must go low before a later rise of the flag can start another conversion.
- R10: A `sw_start` sampled while `busy` is high is ignored.
- R11: A selected line that is already high when reset ends does not produce a start. The first start needs a fresh rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Enables hardware-triggered starts |
| src_sel | input | 3 | Index of the watched trigger line |
| trig_lines | input | 8 | Candidate trigger lines, one bit per source |
| busy | input | 1 | High while the sequencer is converting |
| sw_start | input | 1 | Start request from software |
| conv_start | output | 1 | One-cycle start pulse to the sequencer |
| psc_reset | output | 1 | One-cycle reset pulse for the conversion clock prescaler |

## Verification
The main sweep covers every combination of selected index, raised line and enable state. It raises one line at a time from an all-low idle. This tells a correct select decode apart from a line mapping that is off by one or mirrored, and it shows that the enable gates hardware starts.

Directed sequences then exercise the cases that sort out edge sensing from level sensing:
- lines held high across the fall of `busy`, across reset release, and across a change of `src_sel`;
- edges that arrive during `busy`;
- a flag that is re-raised with and without first being cleared.

Software requests are tried under both enable states and under `busy`. These runs show whether a software start is wrongly gated, and whether it wrongly resets the prescaler.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned NUM_SRC_DEF = 8;

  typedef struct packed {
    logic sw;
    logic hw;
  } start_req_t;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] trig_lines,
  output logic               sel_level
);
  logic [NUM_SRC-1:0] term;

  // AND-OR multiplexer: one decoded term per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
    localparam logic [SEL_W-1:0] IDX = i;
    assign term[i] = trig_lines[i] & (src_sel == IDX);
  end

  assign sel_level = |term;
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             sel_level,
  output logic             rise
);
  logic             lvl_q;
  logic [SEL_W-1:0] sel_q;
  logic             arm_q;

  // History updates every cycle, busy or not, so no stale edge survives
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      sel_q <= '0;
      arm_q <= 1'b0;
    end else begin
      lvl_q <= sel_level;
      sel_q <= src_sel;
      arm_q <= 1'b1;
    end
  end

  // Only a rise seen on an unchanged selection counts
  always_comb begin
    rise = arm_q & sel_level & ~lvl_q & (src_sel == sel_q);
  end
endmodule

// File: rtl/adc_trig_issue.sv
module adc_trig_issue
  import adc_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       busy,
  input  start_req_t req,
  output logic       conv_start,
  output logic       psc_reset
);
  logic hw_go;
  logic sw_go;

  always_comb begin
    hw_go = auto_en & req.hw & ~busy;
    sw_go = req.sw & ~busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_start <= 1'b0;
      psc_reset  <= 1'b0;
    end else begin
      conv_start <= hw_go | sw_go;
      psc_reset  <= hw_go;
    end
  end
endmodule

// File: rtl/adc_trig_start.sv
module adc_trig_start
  import adc_trig_pkg::*;
#(
  parameter int unsigned NUM_SRC = NUM_SRC_DEF,
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_SRC-1:0] trig_lines,
  input  logic               busy,
  input  logic               sw_start,
  output logic               conv_start,
  output logic               psc_reset
);
  logic       sel_level;
  logic       rise;
  start_req_t req;

  adc_trig_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .src_sel    (src_sel),
    .trig_lines (trig_lines),
    .sel_level  (sel_level)
  );

  adc_trig_edge #(.SEL_W(SEL_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .sel_level (sel_level),
    .rise      (rise)
  );

  assign req.sw = sw_start;
  assign req.hw = rise;

  adc_trig_issue u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .busy       (busy),
    .req        (req),
    .conv_start (conv_start),
    .psc_reset  (psc_reset)
  );
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_en,
  input logic [SEL_W-1:0] src_sel,
  input logic             busy,
  input logic             sw_start,
  input logic             conv_start,
  input logic             psc_reset
);
  // R4: a prescaler reset needs the enable in the cycle before
  a_r4_hw_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    psc_reset |-> $past(auto_en));

  // R3: a hardware start always comes with a start pulse
  a_r3_psc_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    psc_reset |-> conv_start);

  // R3: the prescaler reset lasts a single cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    psc_reset |=> !psc_reset);

  // R6: no start of any kind follows a busy cycle
  a_r6_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy));

  // R2: an idle software request is always honoured
  a_r2_sw_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start && !busy) |=> conv_start);

  // R8: a select change cannot start by itself
  a_r8_sel_change: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |=> !psc_reset);
endmodule

bind adc_trig_start adc_trig_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .auto_en    (auto_en),
  .src_sel    (src_sel),
  .busy       (busy),
  .sw_start   (sw_start),
  .conv_start (conv_start),
  .psc_reset  (psc_reset)
);

// File: tb/sim_adc_trig_start.sv
`timescale 1ns/1ps
module sim_adc_trig_start;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_en = 1'b0;
  logic [2:0] src_sel = '0;
  logic [7:0] trig_lines = '0;
  logic       busy = 1'b0;
  logic       sw_start = 1'b0;
  logic       conv_start;
  logic       psc_reset;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  adc_trig_start u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_en),
    .src_sel    (src_sel),
    .trig_lines (trig_lines),
    .busy       (busy),
    .sw_start   (sw_start),
    .conv_start (conv_start),
    .psc_reset  (psc_reset)
  );

  task automatic chk(string req, logic cs_exp, logic pr_exp);
    n_chk++;
    if (conv_start !== cs_exp || psc_reset !== pr_exp) begin
      n_err++;
      $display("FAIL %s: start/psc actual=%b%b expected=%b%b at %0t",
               req, conv_start, psc_reset, cs_exp, pr_exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    trig_lines = '0; busy = 1'b0; sw_start = 1'b0;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    tick(); tick();
    chk("R1", 1'b0, 1'b0);
    // R11: line already high as reset ends
    auto_en = 1'b1; src_sel = 3'd2; trig_lines = 8'h04;
    rst_n = 1'b1;
    tick(); chk("R1", 1'b0, 1'b0);
    tick(); chk("R11", 1'b0, 1'b0);
    idle(2);

    // R3 R4 R5: sweep of select, raised line and enable
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 8; s++) begin
        for (int j = 0; j < 8; j++) begin
          auto_en = en[0]; src_sel = 3'(s);
          idle(2);
          trig_lines = 8'(1 << j);
          tick();
          if (en == 0) chk("R4", 1'b0, 1'b0);
          else if (j == s) chk("R3", 1'b1, 1'b1);
          else chk("R5", 1'b0, 1'b0);
          tick();
          chk("R3", 1'b0, 1'b0);
        end
      end
    end

    // R2: software start under both enable states
    for (int en = 0; en < 2; en++) begin
      auto_en = en[0]; idle(2);
      sw_start = 1'b1; tick(); sw_start = 1'b0;
      chk("R2", 1'b1, 1'b0);
      tick(); chk("R2", 1'b0, 1'b0);
    end

    // R10: software start while busy
    auto_en = 1'b1; idle(2);
    busy = 1'b1; sw_start = 1'b1; tick();
    chk("R10", 1'b0, 1'b0);
    sw_start = 1'b0; busy = 1'b0; tick();
    chk("R10", 1'b0, 1'b0);

    // R6 R7: edge during busy, level held across busy fall
    src_sel = 3'd3; idle(2);
    busy = 1'b1; tick();
    trig_lines = 8'h08; tick();
    chk("R6", 1'b0, 1'b0);
    tick(); busy = 1'b0; tick();
    chk("R6", 1'b0, 1'b0);
    tick(); chk("R7", 1'b0, 1'b0);
    trig_lines = 8'h00; tick();
    trig_lines = 8'h08; tick();
    chk("R7", 1'b1, 1'b1);

    // R8: select moves onto a line that is already high
    src_sel = 3'd0; idle(2);
    trig_lines = 8'h02; tick();
    chk("R8", 1'b0, 1'b0);
    src_sel = 3'd1; tick();
    chk("R8", 1'b0, 1'b0);
    tick(); chk("R8", 1'b0, 1'b0);

    // R9: completion flag on index 7
    src_sel = 3'd7; idle(2);
    trig_lines = 8'h80; tick();
    chk("R9", 1'b1, 1'b1);
    busy = 1'b1; tick(); tick(); busy = 1'b0; tick();
    chk("R9", 1'b0, 1'b0);
    tick(); chk("R9", 1'b0, 1'b0);
    trig_lines = 8'h00; tick();
    chk("R9", 1'b0, 1'b0);
    trig_lines = 8'h80; tick();
    chk("R9", 1'b1, 1'b1);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule